// File: doc/BRIEF.md
# Cross-Bus Access Filter with Show-Cycle Control

This block sits between a local bus and a secondary bus that carries other masters. It holds a three-bit configuration word: a protection flag and a two-bit show-cycle mode. From these it makes two decisions. The first is whether an access by a secondary-bus master to the calibration RAM window on the local side goes through or ends with a data error. The second is whether a local-bus cycle is mirrored as address and data on the secondary bus, so that external equipment can see it.

The calibration RAM window is found by comparing the access address against a base address under a mask. Both are parameters. A secondary-bus access that is not blocked is forwarded at once, with no change. A data error and a show cycle are each a one-cycle pulse, one clock after the request is sampled. A request always uses the configuration held when it is sampled. A configuration write in the same cycle applies only from the next access onward.

Top module: `xbf_top`

## Requirements
- R1: After a synchronous active-low reset, the protection flag and the show-cycle mode are both zero. With these values no error response and no show cycle is produced.
- R2: When the protection flag is set, a secondary-bus request whose address lies in the calibration window is not forwarded, and `sec_err` pulses high for one cycle, in the cycle after the request.
- R3: A secondary-bus request that is outside the window, or that arrives while the protection flag is clear, is forwarded in the same cycle with unchanged address and direction, and no error is raised.
- R4: A configuration write from the secondary side (`sec_cfg_wdata`, bit 0 = protection, bits 2:1 = mode) changes only the mode field. The protection flag keeps its value.
- R5: Mode 2'b00 and the reserved mode 2'b10 produce no show cycles.
- R6: Mode 2'b01 produces a show cycle for local-bus writes only.
- R7: Mode 2'b11 produces a show cycle for both local-bus reads and local-bus writes.
- R8: While the protection flag is set, no show cycle is produced for a local-bus access that falls in the calibration window, whatever the mode. Accesses outside the window still follow the mode.
- R9: A show cycle is a one-cycle `show_stb` pulse in the cycle after the local request. In that cycle `show_addr`, `show_data` and `show_write` carry the address, data and direction of that request.
- R10: A local configuration write (`lcl_cfg_wdata`, same layout as in R4) sets both fields and takes effect from the next cycle. A request in the same cycle uses the old values. If both sides write in the same cycle, the local write wins.
- R11: An address is in the calibration window when `(addr & REGION_MASK) == (REGION_BASE & REGION_MASK)`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lcl_cfg_we | input | 1 | Local-side configuration write strobe |
| lcl_cfg_wdata | input | 3 | Local-side configuration data ([0] protection, [2:1] mode) |
| sec_cfg_we | input | 1 | Secondary-side configuration write strobe |
| sec_cfg_wdata | input | 3 | Secondary-side configuration data (only [2:1] used) |
| sec_req_valid | input | 1 | Secondary-bus request valid |
| sec_req_write | input | 1 | Secondary-bus request is a write |
| sec_req_addr | input | ADDR_W | Secondary-bus request address |
| sec_fwd_valid | output | 1 | Request forwarded to the local bus |
| sec_fwd_write | output | 1 | Forwarded direction |
| sec_fwd_addr | output | ADDR_W | Forwarded address |
| sec_err | output | 1 | Data-error pulse to the secondary bus |
| lb_req_valid | input | 1 | Local-bus cycle valid |
| lb_req_write | input | 1 | Local-bus cycle is a write |
| lb_req_addr | input | ADDR_W | Local-bus cycle address |
| lb_req_data | input | DATA_W | Local-bus cycle data |
| show_stb | output | 1 | Show-cycle pulse |
| show_write | output | 1 | Direction of the shown cycle |
| show_addr | output | ADDR_W | Address of the shown cycle |
| show_data | output | DATA_W | Data of the shown cycle |

## Verification
The bench builds the block with a 16-bit address and data path. It uses a window base of 16'h4000 and a mask of 16'hC000, so the window covers one quarter of the address space. Random addresses therefore land inside and outside the window often, and the window edges at 16'h3FFF/16'h4000 and 16'h7FFF/16'h8000 can be tested directly. The narrow buses also let the random phase cover every combination of protection, mode and direction within a few thousand cycles.

// File: rtl/xbf_pkg.sv
// Shared types for the cross-bus access filter.
// Assumes the configuration word layout [0] protection, [2:1] show mode.
package xbf_pkg;

    typedef enum logic [1:0] {
        SHOW_OFF  = 2'b00,
        SHOW_WR   = 2'b01,
        SHOW_RSVD = 2'b10,
        SHOW_ALL  = 2'b11
    } show_mode_e;

    typedef struct packed {
        show_mode_e mode;
        logic       prot;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    // Returns 1 when the mode asks for a cycle of this direction to be shown.
    function automatic logic show_allowed(input show_mode_e m, input logic wr);
        case (m)
            SHOW_WR:  return wr;
            SHOW_ALL: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/xbf_cfg_reg.sv
// Configuration register of the filter.
// Local side writes every field; secondary side may change only the mode.
// Assumes a local write in the same cycle takes priority.
module xbf_cfg_reg
    import xbf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lcl_we,
    input  cfg_t lcl_wdata,
    input  logic sec_we,
    input  cfg_t sec_wdata,
    output cfg_t cfg
);

    // Hold configuration; the local side wins, the secondary side touches only the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (lcl_we) begin
            cfg <= lcl_wdata;
        end else if (sec_we) begin
            cfg.mode <= sec_wdata.mode;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> cfg == '0);

    a_r4_prot_local_only: assert property (@(posedge clk) disable iff (!rst_n)
        !lcl_we |=> cfg.prot == $past(cfg.prot));

    a_r10_local_wins: assert property (@(posedge clk) disable iff (!rst_n)
        lcl_we |=> cfg == $past(lcl_wdata));

endmodule

// File: rtl/xbf_region_match.sv
// Address compare for the calibration RAM window.
// Assumes BASE and MASK are constants; bits cleared in MASK are ignored.
module xbf_region_match #(
    parameter int              AW   = 32,
    parameter logic [AW-1:0]   BASE = '0,
    parameter logic [AW-1:0]   MASK = '0
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);

    localparam logic [AW-1:0] BASE_M = BASE & MASK;

    // Flag an address whose masked bits equal the masked base.
    always_comb begin
        hit = ((addr & MASK) == BASE_M);
    end

endmodule

// File: rtl/xbf_sec_filter.sv
// Gate for secondary-bus requests into the local bus.
// Blocks window hits while protected and raises a one-cycle error the next cycle.
// Assumes the request is presented for one sampled cycle.
module xbf_sec_filter #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_prot,
    input  logic          hit,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    output logic          fwd_valid,
    output logic          fwd_write,
    output logic [AW-1:0] fwd_addr,
    output logic          err
);

    logic block;

    // Decide whether the current request is refused.
    always_comb begin
        block     = req_valid && hit && cfg_prot;
        fwd_valid = req_valid && !block;
        fwd_write = req_write;
        fwd_addr  = req_addr;
    end

    // Register the error pulse for the cycle after the refused request.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= block;
    end

    a_r2_err_after_block: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && cfg_prot) |=> err);

    a_r2_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($past(req_valid) && $past(cfg_prot) && $past(hit)));

    a_r3_open_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_prot) |-> (fwd_valid && fwd_addr == req_addr));

endmodule

// File: rtl/xbf_show_gen.sv
// Show-cycle generator for local-bus cycles.
// Mirrors address, data and direction one cycle later when the mode allows it
// and the protection flag does not suppress a window hit.
module xbf_show_gen
    import xbf_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cfg_t          cfg,
    input  logic          hit,
    input  logic          lb_valid,
    input  logic          lb_write,
    input  logic [AW-1:0] lb_addr,
    input  logic [DW-1:0] lb_data,
    output logic          stb,
    output logic          show_write,
    output logic [AW-1:0] show_addr,
    output logic [DW-1:0] show_data
);

    logic want;

    // Decide whether this local cycle is to be shown.
    always_comb begin
        want = lb_valid && show_allowed(cfg.mode, lb_write) && !(cfg.prot && hit);
    end

    // Register the strobe and capture the shown cycle's fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb        <= 1'b0;
            show_write <= 1'b0;
            show_addr  <= '0;
            show_data  <= '0;
        end else begin
            stb <= want;
            if (want) begin
                show_write <= lb_write;
                show_addr  <= lb_addr;
                show_data  <= lb_data;
            end
        end
    end

    a_r5_off_modes_silent: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> ($past(cfg.mode) == SHOW_WR || $past(cfg.mode) == SHOW_ALL));

    a_r6_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && $past(cfg.mode) == SHOW_WR) |-> show_write);

    a_r8_prot_suppresses: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && $past(cfg.prot)) |-> !$past(hit));

    a_r9_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> ($past(lb_valid) && show_addr == $past(lb_addr)));

endmodule

// File: rtl/xbf_top.sv
// Cross-bus access filter with show-cycle control.
// Joins the configuration register, two window compares, the secondary-bus
// gate and the show-cycle generator. Bus timing and arbitration lie outside.
module xbf_top
    import xbf_pkg::*;
#(
    parameter int               ADDR_W      = 32,
    parameter int               DATA_W      = 32,
    parameter logic [ADDR_W-1:0] REGION_BASE = 32'h0038_0000,
    parameter logic [ADDR_W-1:0] REGION_MASK = 32'hFFFF_8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lcl_cfg_we,
    input  logic [2:0]        lcl_cfg_wdata,
    input  logic              sec_cfg_we,
    input  logic [2:0]        sec_cfg_wdata,
    input  logic              sec_req_valid,
    input  logic              sec_req_write,
    input  logic [ADDR_W-1:0] sec_req_addr,
    output logic              sec_fwd_valid,
    output logic              sec_fwd_write,
    output logic [ADDR_W-1:0] sec_fwd_addr,
    output logic              sec_err,
    input  logic              lb_req_valid,
    input  logic              lb_req_write,
    input  logic [ADDR_W-1:0] lb_req_addr,
    input  logic [DATA_W-1:0] lb_req_data,
    output logic              show_stb,
    output logic              show_write,
    output logic [ADDR_W-1:0] show_addr,
    output logic [DATA_W-1:0] show_data
);

    localparam int NPORT = 2;

    cfg_t              cfg;
    logic [ADDR_W-1:0] chk_addr [NPORT];
    logic [NPORT-1:0]  chk_hit;

    xbf_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .lcl_we    (lcl_cfg_we),
        .lcl_wdata (cfg_t'(lcl_cfg_wdata)),
        .sec_we    (sec_cfg_we),
        .sec_wdata (cfg_t'(sec_cfg_wdata)),
        .cfg       (cfg)
    );

    // Route each bus address to its own window compare (0 = secondary, 1 = local).
    always_comb begin
        chk_addr[0] = sec_req_addr;
        chk_addr[1] = lb_req_addr;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_match
        xbf_region_match #(
            .AW   (ADDR_W),
            .BASE (REGION_BASE),
            .MASK (REGION_MASK)
        ) u_match (
            .addr (chk_addr[p]),
            .hit  (chk_hit[p])
        );
    end

    xbf_sec_filter #(.AW(ADDR_W)) u_sec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_prot  (cfg.prot),
        .hit       (chk_hit[0]),
        .req_valid (sec_req_valid),
        .req_write (sec_req_write),
        .req_addr  (sec_req_addr),
        .fwd_valid (sec_fwd_valid),
        .fwd_write (sec_fwd_write),
        .fwd_addr  (sec_fwd_addr),
        .err       (sec_err)
    );

    xbf_show_gen #(.AW(ADDR_W), .DW(DATA_W)) u_show (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .hit        (chk_hit[1]),
        .lb_valid   (lb_req_valid),
        .lb_write   (lb_req_write),
        .lb_addr    (lb_req_addr),
        .lb_data    (lb_req_data),
        .stb        (show_stb),
        .show_write (show_write),
        .show_addr  (show_addr),
        .show_data  (show_data)
    );

    a_r9_single_err: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_err && !$past(sec_req_valid, 1)) |-> 1'b0);

endmodule

// File: tb/sim_xbf_top.sv
module sim_xbf_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam logic [AW-1:0] BASE = 16'h4000;
    localparam logic [AW-1:0] MASK = 16'hC000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lcl_cfg_we = 1'b0;
    logic [2:0]    lcl_cfg_wdata = '0;
    logic          sec_cfg_we = 1'b0;
    logic [2:0]    sec_cfg_wdata = '0;
    logic          sec_req_valid = 1'b0;
    logic          sec_req_write = 1'b0;
    logic [AW-1:0] sec_req_addr = '0;
    logic          sec_fwd_valid, sec_fwd_write, sec_err;
    logic [AW-1:0] sec_fwd_addr;
    logic          lb_req_valid = 1'b0;
    logic          lb_req_write = 1'b0;
    logic [AW-1:0] lb_req_addr = '0;
    logic [DW-1:0] lb_req_data = '0;
    logic          show_stb, show_write;
    logic [AW-1:0] show_addr;
    logic [DW-1:0] show_data;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    string dtag = "";

    // Reference configuration.
    logic       m_prot = 1'b0;
    logic [1:0] m_mode = 2'b00;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbf_top #(
        .ADDR_W(AW), .DATA_W(DW), .REGION_BASE(BASE), .REGION_MASK(MASK)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .lcl_cfg_we(lcl_cfg_we), .lcl_cfg_wdata(lcl_cfg_wdata),
        .sec_cfg_we(sec_cfg_we), .sec_cfg_wdata(sec_cfg_wdata),
        .sec_req_valid(sec_req_valid), .sec_req_write(sec_req_write),
        .sec_req_addr(sec_req_addr),
        .sec_fwd_valid(sec_fwd_valid), .sec_fwd_write(sec_fwd_write),
        .sec_fwd_addr(sec_fwd_addr), .sec_err(sec_err),
        .lb_req_valid(lb_req_valid), .lb_req_write(lb_req_write),
        .lb_req_addr(lb_req_addr), .lb_req_data(lb_req_data),
        .show_stb(show_stb), .show_write(show_write),
        .show_addr(show_addr), .show_data(show_data)
    );

    function automatic logic in_win(input logic [AW-1:0] a);
        return (a & MASK) == (BASE & MASK);
    endfunction

    function automatic logic mode_shows(input logic [1:0] m, input logic wr);
        return (m == 2'b11) || (m == 2'b01 && wr);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        string t;
        t = (dtag != "") ? dtag : tag;
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
        end
    endtask

    // One cycle: inputs already set; check combinational, then registered outputs.
    task automatic step();
        logic e_err, e_show, s_hit, l_hit, allow;
        logic          l_wr;
        logic [AW-1:0] l_addr;
        logic [DW-1:0] l_data;
        @(negedge clk);
        #1;
        s_hit = in_win(sec_req_addr);
        l_hit = in_win(lb_req_addr);
        chk(s_hit && m_prot ? "R2" : "R3", 32'(sec_fwd_valid),
            32'(sec_req_valid && !(s_hit && m_prot)));
        if (sec_req_valid && !(s_hit && m_prot)) begin
            chk("R3", 32'(sec_fwd_addr), 32'(sec_req_addr));
            chk("R3", 32'(sec_fwd_write), 32'(sec_req_write));
        end
        e_err  = sec_req_valid && s_hit && m_prot;
        allow  = mode_shows(m_mode, lb_req_write);
        e_show = lb_req_valid && allow && !(m_prot && l_hit);
        l_wr = lb_req_write; l_addr = lb_req_addr; l_data = lb_req_data;
        if (lcl_cfg_we) begin
            m_prot = lcl_cfg_wdata[0];
            m_mode = lcl_cfg_wdata[2:1];
        end else if (sec_cfg_we) begin
            m_mode = sec_cfg_wdata[2:1];
        end
        @(posedge clk);
        #1;
        chk(e_err ? "R2" : "R3", 32'(sec_err), 32'(e_err));
        if (lb_req_valid && allow && m_prot && l_hit)
            chk("R8", 32'(show_stb), 32'(e_show));
        else if (m_mode == 2'b01)
            chk("R6", 32'(show_stb), 32'(e_show));
        else if (m_mode == 2'b11)
            chk("R7", 32'(show_stb), 32'(e_show));
        else
            chk("R5", 32'(show_stb), 32'(e_show));
        if (e_show) begin
            chk("R9", 32'(show_addr), 32'(l_addr));
            chk("R9", 32'(show_data), 32'(l_data));
            chk("R9", 32'(show_write), 32'(l_wr));
        end
    endtask

    task automatic idle();
        lcl_cfg_we = 0; sec_cfg_we = 0; sec_req_valid = 0; lb_req_valid = 0;
    endtask

    task automatic lwrite(input logic [2:0] d);
        idle(); lcl_cfg_we = 1; lcl_cfg_wdata = d; step(); idle();
    endtask

    task automatic sreq(input logic [AW-1:0] a);
        idle(); sec_req_valid = 1; sec_req_write = 1; sec_req_addr = a; step(); idle();
    endtask

    task automatic lreq(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        idle(); lb_req_valid = 1; lb_req_write = wr; lb_req_addr = a; lb_req_data = d;
        step(); idle();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state observed at the ports
        chk("R1", 32'(sec_err), 0);
        chk("R1", 32'(show_stb), 0);
        dtag = "R1";
        lreq(1, 16'h4010, 16'hAAAA);
        sreq(16'h4010);
        dtag = "";

        // R7 / R11: all-show mode, window boundaries
        lwrite(3'b110);
        lreq(0, 16'h3FFF, 16'h1111);
        lreq(1, 16'h8000, 16'h2222);
        lwrite(3'b111);
        dtag = "R11";
        sreq(16'h3FFF); sreq(16'h4000); sreq(16'h7FFF); sreq(16'h8000);
        dtag = "R8";
        lreq(1, 16'h4000, 16'h3333);
        lreq(0, 16'h9000, 16'h4444);
        dtag = "";

        // R4: secondary side cannot clear protection, can change mode
        dtag = "R4";
        idle(); sec_cfg_we = 1; sec_cfg_wdata = 3'b010; step(); idle();
        sreq(16'h5000);
        lreq(0, 16'h1000, 16'h5555);
        lreq(1, 16'h1000, 16'h6666);
        lwrite(3'b000);
        idle(); sec_cfg_we = 1; sec_cfg_wdata = 3'b001; step(); idle();
        sreq(16'h5000);
        dtag = "";

        // R5: reserved mode shows nothing
        lwrite(3'b100);
        lreq(1, 16'h0100, 16'h7777);
        lreq(0, 16'h0100, 16'h7777);

        // R10: same-cycle write and request uses old settings; local wins
        dtag = "R10";
        idle(); lcl_cfg_we = 1; lcl_cfg_wdata = 3'b111;
        sec_req_valid = 1; sec_req_addr = 16'h4444;
        lb_req_valid = 1; lb_req_write = 1; lb_req_addr = 16'h1234; lb_req_data = 16'h8888;
        step(); idle();
        sreq(16'h4444);
        idle(); lcl_cfg_we = 1; lcl_cfg_wdata = 3'b010;
        sec_cfg_we = 1; sec_cfg_wdata = 3'b110; step(); idle();
        lreq(0, 16'h1234, 16'h9999);
        sreq(16'h4444);
        dtag = "";

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            lcl_cfg_we    = ($urandom % 12) == 0;
            lcl_cfg_wdata = 3'($urandom);
            sec_cfg_we    = ($urandom % 8) == 0;
            sec_cfg_wdata = 3'($urandom);
            sec_req_valid = $urandom % 2;
            sec_req_write = $urandom % 2;
            sec_req_addr  = AW'($urandom);
            lb_req_valid  = $urandom % 2;
            lb_req_write  = $urandom % 2;
            lb_req_addr   = AW'($urandom);
            lb_req_data   = DW'($urandom);
            step();
        end
        idle();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule